// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two parallel buses, called A and B, through non-inverting channels. Each travel direction has its own capture register. The A-to-B register stores A-bus data and the B-to-A register stores B-bus data. Each direction also has a selector that puts either the live data from the far bus or the stored word onto the receiving bus. An active-low enable and a direction input decide which bus, if either, the block drives. The registers keep capturing whether or not any bus is driven, so a word can be parked while both sides are isolated and replayed later.

The channels are split into groups, by default two groups of eight bits. Each group has its own complete control set: direction, enable, two capture strobes and two selectors. Tri-state buses appear as separate input, output and output-enable vectors, so the pad ring can build the real bidirectional pins. Capture events are strobes sampled on one common system clock.

Top module: `dual_bus_xcvr`

## Requirements
- R1: A synchronous active-low reset clears both registers of every group to zero, and capture strobes are ignored while reset is held.
- R2: At a clock edge with `cap_ab[g]` high, the A-to-B register of group g loads that group's slice of `a_in`. With the strobe low, the register holds its value.
- R3: At a clock edge with `cap_ba[g]` high, the B-to-A register of group g loads that group's slice of `b_in`. With the strobe low, the register holds its value.
- R4: With `oe_n[g]`=0 and `dir[g]`=1, all bits of group g in `b_oe` are 1 and all bits of group g in `a_oe` are 0.
- R5: With `oe_n[g]`=0 and `dir[g]`=0, all bits of group g in `a_oe` are 1 and all bits of group g in `b_oe` are 0.
- R6: With `oe_n[g]`=1, group g drives neither bus: its `a_oe`, `b_oe`, `a_out` and `b_out` bits are all 0.
- R7: A selector at 0 (live) drives the enabled bus with the other bus's input for that group, unchanged and in the same cycle. `sel_ab` governs `b_out` and `sel_ba` governs `a_out`.
- R8: A selector at 1 (stored) drives the enabled bus with that direction's register: `b_out` from the A-to-B register and `a_out` from the B-to-A register.
- R9: Both registers capture while `oe_n[g]`=1, and the captured words are visible once the group is enabled with the stored selection.
- R10: Groups are independent. No control or data input of one group changes any output or register of another group.
- R11: Within a group, `a_oe` and `b_oe` are never both active.
- R12: Capture works whichever direction is enabled. Both registers of a group may load in the same edge while the group drives a bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; capture strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | GROUPS*GROUP_W (16) | Value seen on the A bus |
| a_out | output | GROUPS*GROUP_W (16) | Value the block drives toward the A bus |
| a_oe | output | GROUPS*GROUP_W (16) | Per-bit enable of the A-bus drivers |
| b_in | input | GROUPS*GROUP_W (16) | Value seen on the B bus |
| b_out | output | GROUPS*GROUP_W (16) | Value the block drives toward the B bus |
| b_oe | output | GROUPS*GROUP_W (16) | Per-bit enable of the B-bus drivers |
| dir | input | GROUPS (2) | Per group: 1 drives B from the A side, 0 drives A from the B side |
| oe_n | input | GROUPS (2) | Per group active-low output enable |
| cap_ab | input | GROUPS (2) | Per group capture strobe of the A-to-B register |
| cap_ba | input | GROUPS (2) | Per group capture strobe of the B-to-A register |
| sel_ab | input | GROUPS (2) | Per group source for `b_out`: 0 live, 1 stored |
| sel_ba | input | GROUPS (2) | Per group source for `a_out`: 0 live, 1 stored |

## Verification
The assertions check on every cycle that a group never enables both buses and that an isolated group enables no driver. They also check that a strobed register holds the sampled input one cycle later, that an unstrobed register stays unchanged, and that a stored selection on an enabled bus shows the register. Other behaviours can only be shown by the bench's scenarios: reset clearing, capture while isolated, capture while driving, and the independence of the two groups. These depend on sequences of strobes followed by later readback, so the bench sweeps every control combination per group over several data patterns.

// File: rtl/xcvr_pkg.sv
// Shared definitions for the registered bus transceiver.
// Assumes: one selector bit per direction, 0 = live, 1 = stored.
package xcvr_pkg;
    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_sel_e;
endpackage

// File: rtl/xcvr_store_reg.sv
// Capture register for one direction of one group.
// Loads d on a clock edge where cap is high; otherwise holds.
// Assumes: synchronous active-low reset has priority over cap.
module xcvr_store_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Purpose: clear on reset, load on strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (cap)
            q <= d;
    end

    // R2 R3
    capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && rst_n) |=> (q == $past(d)));

    // R2 R3
    capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap && $past(rst_n)) |=> $stable(q));
endmodule

// File: rtl/xcvr_drive_ctl.sv
// Output steering for one group: picks live or stored data per direction
// and enables at most one bus according to oe_n and dir.
// Assumes: disabled outputs are driven to zero so idle values are known.
module xcvr_drive_ctl
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         oe_n,
    input  logic         dir,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic [W-1:0] a_live,
    input  logic [W-1:0] b_live,
    input  logic [W-1:0] q_ab,
    input  logic [W-1:0] q_ba,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe
);
    logic     drive_a;
    logic     drive_b;
    src_sel_e src_b;
    src_sel_e src_a;

    // Purpose: decode which bus this group drives.
    always_comb begin
        drive_b = !oe_n && dir;
        drive_a = !oe_n && !dir;
        src_b   = src_sel_e'(sel_ab);
        src_a   = src_sel_e'(sel_ba);
    end

    // Purpose: steer B-bus data and enables.
    always_comb begin
        b_oe  = {W{drive_b}};
        b_out = '0;
        if (drive_b)
            b_out = (src_b == SRC_STORED) ? q_ab : a_live;
    end

    // Purpose: steer A-bus data and enables.
    always_comb begin
        a_oe  = {W{drive_a}};
        a_out = '0;
        if (drive_a)
            a_out = (src_a == SRC_STORED) ? q_ba : b_live;
    end
endmodule

// File: rtl/xcvr_group.sv
// One independent transceiver group: two capture registers plus steering.
// Assumes: strobes are single-cycle enables on the system clock.
module xcvr_group #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dir,
    input  logic         oe_n,
    input  logic         cap_ab,
    input  logic         cap_ba,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe
);
    logic [W-1:0] q_ab;
    logic [W-1:0] q_ba;

    xcvr_store_reg #(.W(W)) u_reg_ab (
        .clk(clk), .rst_n(rst_n), .cap(cap_ab), .d(a_in), .q(q_ab)
    );

    xcvr_store_reg #(.W(W)) u_reg_ba (
        .clk(clk), .rst_n(rst_n), .cap(cap_ba), .d(b_in), .q(q_ba)
    );

    xcvr_drive_ctl #(.W(W)) u_drive (
        .oe_n(oe_n), .dir(dir), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .a_live(a_in), .b_live(b_in), .q_ab(q_ab), .q_ba(q_ba),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
    );

    // R11
    oe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((|a_oe) && (|b_oe)));

    // R6
    isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (a_oe == '0 && b_oe == '0 && a_out == '0 && b_out == '0));

    // R8
    stored_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && dir && sel_ab) |-> (b_out == q_ab));

    // R8
    stored_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && !dir && sel_ba) |-> (a_out == q_ba));
endmodule

// File: rtl/dual_bus_xcvr.sv
// Top level: GROUPS independent transceiver groups of GROUP_W bits each.
// Assumes: tri-state pads are built outside from the out/oe vectors.
module dual_bus_xcvr #(
    parameter int GROUPS  = 2,
    parameter int GROUP_W = 8,
    localparam int BUS_W  = GROUPS * GROUP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_W-1:0]  a_in,
    output logic [BUS_W-1:0]  a_out,
    output logic [BUS_W-1:0]  a_oe,
    input  logic [BUS_W-1:0]  b_in,
    output logic [BUS_W-1:0]  b_out,
    output logic [BUS_W-1:0]  b_oe,
    input  logic [GROUPS-1:0] dir,
    input  logic [GROUPS-1:0] oe_n,
    input  logic [GROUPS-1:0] cap_ab,
    input  logic [GROUPS-1:0] cap_ba,
    input  logic [GROUPS-1:0] sel_ab,
    input  logic [GROUPS-1:0] sel_ba
);
    // Purpose: replicate one group per control set.
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        xcvr_group #(.W(GROUP_W)) u_grp (
            .clk   (clk),
            .rst_n (rst_n),
            .dir   (dir[g]),
            .oe_n  (oe_n[g]),
            .cap_ab(cap_ab[g]),
            .cap_ba(cap_ba[g]),
            .sel_ab(sel_ab[g]),
            .sel_ba(sel_ba[g]),
            .a_in  (a_in [g*GROUP_W +: GROUP_W]),
            .b_in  (b_in [g*GROUP_W +: GROUP_W]),
            .a_out (a_out[g*GROUP_W +: GROUP_W]),
            .a_oe  (a_oe [g*GROUP_W +: GROUP_W]),
            .b_out (b_out[g*GROUP_W +: GROUP_W]),
            .b_oe  (b_oe [g*GROUP_W +: GROUP_W])
        );
    end
endmodule

// File: tb/dual_bus_xcvr_bench.sv
module dual_bus_xcvr_bench;
    localparam int G = 2;
    localparam int W = 8;
    localparam int N = G * W;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] a_in, b_in;
    logic [N-1:0] a_out, a_oe, b_out, b_oe;
    logic [G-1:0] dir, oe_n, cap_ab, cap_ba, sel_ab, sel_ba;

    logic [W-1:0] ref_ab [G];
    logic [W-1:0] ref_ba [G];
    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    dual_bus_xcvr #(.GROUPS(G), .GROUP_W(W)) u_dual_bus_xcvr (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .dir(dir), .oe_n(oe_n), .cap_ab(cap_ab), .cap_ba(cap_ba),
        .sel_ab(sel_ab), .sel_ba(sel_ba)
    );

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Clock edge: update reference registers from strobes, release strobes.
    task automatic tick();
        @(posedge clk);
        for (int g = 0; g < G; g++) begin
            if (!rst_n) begin
                ref_ab[g] = '0;  // R1
                ref_ba[g] = '0;
            end else begin
                if (cap_ab[g]) ref_ab[g] = a_in[g*W +: W];  // R2
                if (cap_ba[g]) ref_ba[g] = b_in[g*W +: W];  // R3
            end
        end
        @(negedge clk);
        cap_ab = '0;
        cap_ba = '0;
    endtask

    // Compare all outputs of all groups against the reference model.
    task automatic check_all(string ctx);
        #1;
        for (int g = 0; g < G; g++) begin
            logic         db, da;
            logic [W-1:0] eb, ea;
            db = !oe_n[g] && dir[g];
            da = !oe_n[g] && !dir[g];
            eb = db ? (sel_ab[g] ? ref_ab[g] : a_in[g*W +: W]) : '0;
            ea = da ? (sel_ba[g] ? ref_ba[g] : b_in[g*W +: W]) : '0;
            chk(oe_n[g] ? {"R6 b_oe ", ctx} : (dir[g] ? {"R4 b_oe ", ctx} : {"R5 b_oe ", ctx}),
                b_oe[g*W +: W], {W{db}});
            chk(oe_n[g] ? {"R6 a_oe ", ctx} : (dir[g] ? {"R4 a_oe ", ctx} : {"R5 a_oe ", ctx}),
                a_oe[g*W +: W], {W{da}});
            chk(!db ? {"R6 b_out ", ctx} : (sel_ab[g] ? {"R8 b_out ", ctx} : {"R7 b_out ", ctx}),
                b_out[g*W +: W], eb);
            chk(!da ? {"R6 a_out ", ctx} : (sel_ba[g] ? {"R8 a_out ", ctx} : {"R7 a_out ", ctx}),
                a_out[g*W +: W], ea);
            // R11
            chk({"R11 ", ctx}, {7'd0, (|a_oe[g*W +: W]) && (|b_oe[g*W +: W])}, 8'd0);
        end
    endtask

    initial begin
        rst_n = 1'b0; a_in = 16'h5A3C; b_in = 16'hC3A5;
        dir = '1; oe_n = '0; cap_ab = '1; cap_ba = '1; sel_ab = '1; sel_ba = '1;
        for (int g = 0; g < G; g++) begin ref_ab[g] = 'x; ref_ba[g] = 'x; end
        @(negedge clk);
        cap_ab = '1; cap_ba = '1;
        tick();
        cap_ab = '1; cap_ba = '1;
        tick();
        // R1: strobes during reset ignored, registers read zero
        rst_n = 1'b1;
        dir = 2'b01;
        check_all("R1 reset");
        dir = 2'b10;
        check_all("R1 reset");

        // Sweep: all 16 control combos per group, several data patterns (R12, R10)
        for (int p = 0; p < 6; p++) begin
            for (int c = 0; c < 16; c++) begin
                logic [3:0] c1;
                c1 = 4'(c) ^ 4'(p + 5);
                a_in   = 16'hA5C3 ^ 16'(p * 16'h1357 + c * 16'h0F1);
                b_in   = 16'h3C96 ^ 16'(p * 16'h2468 + c * 16'h10B);
                dir    = {c1[0], 1'(c)};
                oe_n   = {c1[1], 1'(c >> 1)};
                sel_ab = {c1[2], 1'(c >> 2)};
                sel_ba = {c1[3], 1'(c >> 3)};
                check_all("R7 R10 live sweep");
                cap_ab = 2'(p + c);
                cap_ba = 2'(p ^ c);
                tick();
                check_all("R12 R10 post capture");
            end
        end

        // R9: capture both registers while both groups isolated
        oe_n = '1; a_in = 16'h1E2D; b_in = 16'h4B78;
        cap_ab = '1; cap_ba = '1;
        tick();
        check_all("R9 isolated");
        a_in = 16'hFFFF; b_in = 16'h0000;
        oe_n = '0; sel_ab = '1; sel_ba = '1;
        dir = 2'b11; check_all("R9 readback B");
        dir = 2'b00; check_all("R9 readback A");

        // R2 R3 hold: no strobe, inputs change, registers unchanged
        a_in = 16'h0F0F; b_in = 16'hF0F0;
        tick(); tick();
        dir = 2'b11; check_all("R2 hold");
        dir = 2'b00; check_all("R3 hold");

        // R10: strobe only group 0; group 1 registers keep old value
        a_in = 16'h6699; b_in = 16'h9966;
        cap_ab = 2'b01; cap_ba = 2'b01;
        tick();
        dir = 2'b11; check_all("R10 group0 only");
        dir = 2'b00; check_all("R10 group0 only");

        // R12: both registers load in one edge while B is driven
        dir = 2'b11; oe_n = '0; a_in = 16'h7721; b_in = 16'h3388;
        cap_ab = '1; cap_ba = '1;
        tick();
        a_in = '0; b_in = '0;
        check_all("R12 while driving B");
        dir = 2'b00; check_all("R12 while driving B");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog act=hung exp=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule